// File: doc/BRIEF.md
# Processor Trap and Exception Entry Controller

This block is the trap unit of a small 32-bit RISC core. The pipeline sends it one-cycle strobes for a breakpoint, a system call, a data bus error (an unmapped or misaligned access) and an unsigned divide or modulus, together with the address of the instruction concerned. The unit also raises an interrupt by itself when interrupts are globally enabled and a pending line is unmasked. In the cycle of an event it produces a PC redirect to a vector, and a register-file write that saves the instruction address. On the following clock edge it updates the interrupt-enable state.

The unit holds five control registers. They are read and written through a simple CSR port with a select code: IE (0), IM (1), IP (2), EBA (3) and DEBA (4). IE holds three bits: bit 0 is the global enable, bit 1 is the copy saved on a normal exception, and bit 2 is the copy saved on a breakpoint. The unit watches for the return-from-trap branch and restores the global enable from the saved copy that belongs to the register the branch targets. Exception identifiers are breakpoint 1, data bus error 4, divide-by-zero 5, interrupt 6 and system call 7.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, IE, IM, IP, EBA and DEBA all read 0, and with no event there is no redirect and no register write.
- R2: A data bus error, a divide-by-zero, a system call or a taken interrupt asserts the redirect to EBA + id*32. In the same cycle it writes the instruction address to register 30.
- R3: A breakpoint asserts the redirect to DEBA + 32 and writes the instruction address to register 31 in the same cycle.
- R4: After a non-breakpoint trap, IE reads as old bit 0 placed in bit 1, with every other bit 0.
- R5: After a breakpoint, IE reads as old bit 0 placed in bit 2, with every other bit 0.
- R6: A return branch through register 30 sets IE to old bit 1 in bit 0, with the other bits 0. A return through register 31 does the same using old bit 2. A return through any other register leaves IE unchanged. A return never causes a redirect.
- R7: A write to IP (select 2) clears every bit written as 1 and keeps every bit written as 0. An interrupt line that is high sets its IP bit on the next edge, and a set takes priority over a clear in the same cycle. Writes to IE, IM, EBA and DEBA replace their contents. Bits 7:0 of EBA and DEBA always read 0.
- R8: A divide with a zero divisor raises trap id 5 and keeps the result commit low. A divide with a nonzero divisor asserts the result commit and causes no redirect.
- R9: An interrupt is taken when IE bit 0 is 1 and IP AND IM is nonzero. A pending line that is masked in IM, or a global enable that is 0, causes no redirect.
- R10: When several events arrive in one cycle, only the one with the lowest id is taken. It alone decides the vector, the saved register and the IE update.
- R11: In one cycle a trap outranks a return branch, and a return branch outranks a CSR write to IE, in deciding the new IE value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Address of the current instruction |
| brk_i | input | 1 | Breakpoint strobe |
| scall_i | input | 1 | System call strobe |
| dbe_i | input | 1 | Data bus error strobe (unmapped or misaligned) |
| div_op_i | input | 1 | Unsigned divide or modulus strobe |
| divisor_i | input | 32 | Divisor operand of the divide |
| irq_i | input | 8 | Interrupt request lines |
| ret_i | input | 1 | Return branch strobe |
| ret_reg_i | input | 5 | Register index that the return branch targets |
| csr_we_i | input | 1 | CSR write enable |
| csr_sel_i | input | 3 | CSR select code |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for the selected register |
| redirect_o | output | 1 | Take trap: redirect the PC |
| redirect_pc_o | output | 32 | Handler vector |
| gpr_we_o | output | 1 | Register file write enable for the saved address |
| gpr_addr_o | output | 5 | Register index to write (30 or 31) |
| gpr_wdata_o | output | 32 | Saved instruction address |
| div_commit_o | output | 1 | Divide result may be written back |

## Verification
A wrong saved-enable bit stays hidden until a return branch copies it into bit 0. It then shows as an interrupt taken or missed on the next cycle that has pending unmasked lines. For this reason the tests read IE back right after each trap and each return. A wrong priority or a wrong vector id shows at once on the redirect target and on the saved-register index in the same cycle as the strobe. A stale IP bit shows as a repeated interrupt on the first cycle in which the global enable is set again.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int AW   = 32,
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   pc_i,
  input  logic            brk_i,
  input  logic            scall_i,
  input  logic            dbe_i,
  input  logic            div_op_i,
  input  logic [AW-1:0]   divisor_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            ret_i,
  input  logic [4:0]      ret_reg_i,
  input  logic            csr_we_i,
  input  logic [2:0]      csr_sel_i,
  input  logic [AW-1:0]   csr_wdata_i,
  output logic [AW-1:0]   csr_rdata_o,
  output logic            redirect_o,
  output logic [AW-1:0]   redirect_pc_o,
  output logic            gpr_we_o,
  output logic [4:0]      gpr_addr_o,
  output logic [AW-1:0]   gpr_wdata_o,
  output logic            div_commit_o
);
  localparam int BW = AW - 8;
  localparam logic [2:0] SEL_IE = 3'd0, SEL_IM = 3'd1, SEL_IP = 3'd2,
                         SEL_EBA = 3'd3, SEL_DEBA = 3'd4;
  localparam logic [2:0] ID_BRK = 3'd1, ID_DBE = 3'd4, ID_DIVZ = 3'd5,
                         ID_IRQ = 3'd6, ID_SCALL = 3'd7;
  localparam logic [4:0] REG_EA = 5'd30, REG_BA = 5'd31;

  logic [2:0]      ie_q;
  logic [NIRQ-1:0] im_q, ip_q;
  logic [BW-1:0]   eba_q, deba_q;
  logic            take, dbg;
  logic [2:0]      id;

  wire div_zero = div_op_i && (divisor_i == '0);
  wire irq_req  = ie_q[0] && |(ip_q & im_q);

  always_comb begin
    take = 1'b1;
    dbg  = 1'b0;
    id   = ID_BRK;
    if (brk_i)         dbg = 1'b1;
    else if (dbe_i)    id  = ID_DBE;
    else if (div_zero) id  = ID_DIVZ;
    else if (irq_req)  id  = ID_IRQ;
    else if (scall_i)  id  = ID_SCALL;
    else               take = 1'b0;
  end

  assign redirect_o    = take;
  assign redirect_pc_o = {dbg ? deba_q : eba_q, id, 5'b0};
  assign gpr_we_o      = take;
  assign gpr_addr_o    = dbg ? REG_BA : REG_EA;
  assign gpr_wdata_o   = pc_i;
  assign div_commit_o  = div_op_i && !div_zero && !take;

  wire wr_ie   = csr_we_i && csr_sel_i == SEL_IE;
  wire wr_im   = csr_we_i && csr_sel_i == SEL_IM;
  wire wr_ip   = csr_we_i && csr_sel_i == SEL_IP;
  wire wr_eba  = csr_we_i && csr_sel_i == SEL_EBA;
  wire wr_deba = csr_we_i && csr_sel_i == SEL_DEBA;
  wire [NIRQ-1:0] ip_clr = wr_ip ? csr_wdata_i[NIRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (take) begin
      ie_q <= dbg ? {ie_q[0], 2'b00} : {1'b0, ie_q[0], 1'b0};
    end else if (ret_i && ret_reg_i == REG_EA) begin
      ie_q <= {2'b00, ie_q[1]};
    end else if (ret_i && ret_reg_i == REG_BA) begin
      ie_q <= {2'b00, ie_q[2]};
    end else if (wr_ie) begin
      ie_q <= csr_wdata_i[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      im_q   <= '0;
      ip_q   <= '0;
      eba_q  <= '0;
      deba_q <= '0;
    end else begin
      ip_q <= (ip_q & ~ip_clr) | irq_i;
      if (wr_im)   im_q   <= csr_wdata_i[NIRQ-1:0];
      if (wr_eba)  eba_q  <= csr_wdata_i[AW-1:8];
      if (wr_deba) deba_q <= csr_wdata_i[AW-1:8];
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    case (csr_sel_i)
      SEL_IE:   csr_rdata_o[2:0]      = ie_q;
      SEL_IM:   csr_rdata_o[NIRQ-1:0] = im_q;
      SEL_IP:   csr_rdata_o[NIRQ-1:0] = ip_q;
      SEL_EBA:  csr_rdata_o           = {eba_q, 8'h00};
      SEL_DEBA: csr_rdata_o           = {deba_q, 8'h00};
      default:  csr_rdata_o           = '0;
    endcase
  end
endmodule

module trap_ctrl_chk #(
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redirect,
  input logic [7:0]      vec_lo,
  input logic            gpr_we,
  input logic [4:0]      gpr_addr,
  input logic            div_commit,
  input logic [2:0]      ie,
  input logic [NIRQ-1:0] ip,
  input logic [NIRQ-1:0] im,
  input logic            ret,
  input logic [4:0]      ret_reg,
  input logic            any_ev
);
  p_save_with_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> redirect && (gpr_addr == 5'd30 || gpr_addr == 5'd31));

  p_vector_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> vec_lo[4:0] == 5'd0);

  p_ie_save_nondebug_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && gpr_addr == 5'd30 |=> ie == {1'b0, $past(ie[0]), 1'b0});

  p_ie_save_debug_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && gpr_addr == 5'd31 |=> ie == {$past(ie[0]), 2'b00});

  p_ret_ea_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret && ret_reg == 5'd30 && !redirect |=> ie == {2'b00, $past(ie[1])});

  p_ret_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret && ret_reg == 5'd31 && !redirect |=> ie == {2'b00, $past(ie[2])});

  p_commit_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_commit |-> !redirect);

  p_irq_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ie[0] && (ip & im) != '0 && !any_ev |-> redirect && vec_lo[7:5] == 3'd6);
endmodule

bind trap_ctrl trap_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .redirect(redirect_o), .vec_lo(redirect_pc_o[7:0]),
  .gpr_we(gpr_we_o), .gpr_addr(gpr_addr_o), .div_commit(div_commit_o),
  .ie(ie_q), .ip(ip_q), .im(im_q), .ret(ret_i), .ret_reg(ret_reg_i),
  .any_ev(brk_i || dbe_i || div_op_i || scall_i)
);

// File: tb/sim_trap_ctrl.sv
module sim_trap_ctrl;
  localparam int PERIOD = 10;
  localparam logic [2:0] S_IE = 0, S_IM = 1, S_IP = 2, S_EBA = 3, S_DEBA = 4;

  logic clk = 0, rst_n = 0;
  logic [31:0] pc_i = 0, divisor_i = 0, csr_wdata_i = 0;
  logic brk_i = 0, scall_i = 0, dbe_i = 0, div_op_i = 0, ret_i = 0, csr_we_i = 0;
  logic [7:0] irq_i = 0;
  logic [4:0] ret_reg_i = 0;
  logic [2:0] csr_sel_i = 0;
  logic [31:0] csr_rdata_o, redirect_pc_o, gpr_wdata_o;
  logic redirect_o, gpr_we_o, div_commit_o;
  logic [4:0] gpr_addr_o;
  int n_chk = 0, n_err = 0;
  logic [31:0] rd;

  trap_ctrl u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(logic [2:0] sel, logic [31:0] v);
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = v;
    @(negedge clk);
    csr_we_i = 0;
  endtask

  task automatic csr_rd(logic [2:0] sel, output logic [31:0] v);
    @(negedge clk);
    csr_sel_i = sel;
    #1 v = csr_rdata_o;
  endtask

  task automatic clear_ev();
    brk_i = 0; scall_i = 0; dbe_i = 0; div_op_i = 0; ret_i = 0; divisor_i = 0;
  endtask

  task automatic expect_trap(string req, logic [31:0] vec, logic [4:0] ra, logic [31:0] pc);
    #1;
    chk({req, " redirect"}, {31'b0, redirect_o}, 1);
    chk({req, " vector"}, redirect_pc_o, vec);
    chk({req, " gpr_we"}, {31'b0, gpr_we_o}, 1);
    chk({req, " gpr_addr"}, {27'b0, gpr_addr_o}, {27'b0, ra});
    chk({req, " gpr_data"}, gpr_wdata_o, pc);
    @(negedge clk);
    clear_ev();
  endtask

  task automatic t_reset();
    for (int s = 0; s < 5; s++) begin
      csr_rd(3'(s), rd);
      chk("R1 csr reset", rd, 0);
    end
    chk("R1 no redirect", {31'b0, redirect_o}, 0);
    chk("R1 no gpr write", {31'b0, gpr_we_o}, 0);
  endtask

  task automatic t_csr();
    csr_wr(S_EBA, 32'h0000_12FF);
    csr_rd(S_EBA, rd);  chk("R7 eba low bits forced", rd, 32'h0000_1200);
    csr_wr(S_DEBA, 32'h0000_3477);
    csr_rd(S_DEBA, rd); chk("R7 deba low bits forced", rd, 32'h0000_3400);
    csr_wr(S_IM, 32'h0000_00A5);
    csr_rd(S_IM, rd);   chk("R7 im replace", rd, 32'h0000_00A5);
    @(negedge clk); irq_i = 8'h0F;
    @(negedge clk); irq_i = 0;
    csr_rd(S_IP, rd);   chk("R7 ip set by lines", rd, 32'h0F);
    csr_wr(S_IP, 32'h0000_0005);
    csr_rd(S_IP, rd);   chk("R7 ip w1c", rd, 32'h0A);
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = S_IP; csr_wdata_i = 32'h0A; irq_i = 8'h02;
    @(negedge clk);
    csr_we_i = 0; irq_i = 0;
    csr_rd(S_IP, rd);   chk("R7 ip set beats clear", rd, 32'h02);
    csr_wr(S_IP, 32'hFF);
    csr_rd(S_IP, rd);   chk("R7 ip cleared", rd, 0);
    csr_wr(S_IM, 0);
  endtask

  task automatic t_brk();
    csr_wr(S_IE, 1);
    @(negedge clk); pc_i = 32'h0000_0400; brk_i = 1;
    expect_trap("R3 brk", 32'h0000_3420, 5'd31, 32'h400);
    csr_rd(S_IE, rd); chk("R5 ie after brk", rd, 32'h4);
  endtask

  task automatic t_nondebug();
    csr_wr(S_IE, 1);
    @(negedge clk); pc_i = 32'h0000_0500; dbe_i = 1;
    expect_trap("R2 dbe", 32'h0000_1280, 5'd30, 32'h500);
    csr_rd(S_IE, rd); chk("R4 ie after dbe", rd, 32'h2);
    csr_wr(S_IE, 0);
    @(negedge clk); pc_i = 32'h0000_0504; scall_i = 1;
    expect_trap("R2 scall", 32'h0000_12E0, 5'd30, 32'h504);
    csr_rd(S_IE, rd); chk("R4 ie after scall from 0", rd, 32'h0);
  endtask

  task automatic t_div();
    csr_wr(S_IE, 1);
    @(negedge clk); pc_i = 32'h0000_0600; div_op_i = 1; divisor_i = 7;
    #1;
    chk("R8 nonzero commit", {31'b0, div_commit_o}, 1);
    chk("R8 nonzero no redirect", {31'b0, redirect_o}, 0);
    @(negedge clk); clear_ev();
    csr_rd(S_IE, rd); chk("R8 ie untouched", rd, 1);
    @(negedge clk); pc_i = 32'h0000_0604; div_op_i = 1; divisor_i = 0;
    #1 chk("R8 zero no commit", {31'b0, div_commit_o}, 0);
    expect_trap("R8 divz", 32'h0000_12A0, 5'd30, 32'h604);
  endtask

  task automatic t_ret();
    int regs[4] = '{30, 31, 5, 30};
    logic [2:0] pre[4] = '{3'b010, 3'b100, 3'b011, 3'b001};
    logic [2:0] post[4] = '{3'b001, 3'b001, 3'b011, 3'b000};
    for (int i = 0; i < 4; i++) begin
      csr_wr(S_IE, {29'b0, pre[i]});
      @(negedge clk); ret_i = 1; ret_reg_i = 5'(regs[i]);
      #1 chk("R6 ret no redirect", {31'b0, redirect_o}, 0);
      @(negedge clk); clear_ev();
      csr_rd(S_IE, rd); chk("R6 ie after ret", rd, {29'b0, post[i]});
    end
  endtask

  task automatic t_irq();
    csr_wr(S_IE, 0);
    csr_wr(S_IM, 32'h04);
    @(negedge clk); irq_i = 8'h04;
    @(negedge clk); irq_i = 0;
    #1 chk("R9 global disable blocks", {31'b0, redirect_o}, 0);
    csr_wr(S_IM, 32'h08);
    csr_wr(S_IE, 1);
    #1 chk("R9 mask blocks", {31'b0, redirect_o}, 0);
    csr_wr(S_IM, 32'h04);
    pc_i = 32'h0000_0700;
    expect_trap("R9 irq", 32'h0000_12C0, 5'd30, 32'h700);
    csr_rd(S_IE, rd); chk("R4 ie after irq", rd, 32'h2);
    csr_rd(S_IP, rd); chk("R9 ip still pending", rd, 32'h04);
    csr_wr(S_IP, 32'h04);
    csr_wr(S_IM, 0);
  endtask

  task automatic t_priority();
    csr_wr(S_IE, 1);
    @(negedge clk); pc_i = 32'h0000_0800; brk_i = 1; dbe_i = 1; scall_i = 1;
    expect_trap("R10 brk first", 32'h0000_3420, 5'd31, 32'h800);
    csr_rd(S_IE, rd); chk("R10 ie by brk", rd, 32'h4);
    csr_wr(S_IE, 1);
    @(negedge clk); pc_i = 32'h0000_0804; div_op_i = 1; divisor_i = 0; scall_i = 1;
    expect_trap("R10 divz over scall", 32'h0000_12A0, 5'd30, 32'h804);
    csr_wr(S_IE, 1);
    @(negedge clk); pc_i = 32'h0000_0808; dbe_i = 1; div_op_i = 1; divisor_i = 0;
    expect_trap("R10 dbe over divz", 32'h0000_1280, 5'd30, 32'h808);
  endtask

  task automatic t_precedence();
    csr_wr(S_IE, 1);
    @(negedge clk);
    scall_i = 1; ret_i = 1; ret_reg_i = 30;
    csr_we_i = 1; csr_sel_i = S_IE; csr_wdata_i = 32'h7;
    @(negedge clk); clear_ev(); csr_we_i = 0;
    csr_rd(S_IE, rd); chk("R11 trap beats ret and write", rd, 32'h2);
    @(negedge clk);
    ret_i = 1; ret_reg_i = 30;
    csr_we_i = 1; csr_sel_i = S_IE; csr_wdata_i = 32'h4;
    @(negedge clk); clear_ev(); csr_we_i = 0;
    csr_rd(S_IE, rd); chk("R11 ret beats write", rd, 32'h1);
  endtask

  initial begin
    #(PERIOD * 50000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 3);
    rst_n = 1;
    t_reset();
    t_csr();
    t_brk();
    t_nondebug();
    t_div();
    t_ret();
    t_irq();
    t_priority();
    t_precedence();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule